// File: doc/BRIEF.md
# PWM Global Enable and Interrupt Controller

This block is the shared control front end of a multi-channel pulse-width modulator. It owns one run-enable bit and one interrupt-mask bit per channel. Software changes them through paired write-one-to-set and write-one-to-clear registers, so it can change one channel without a read-modify-write. The block also latches a pending bit whenever an enabled channel reports the end of a period. Reading the pending register returns the latched bits and clears exactly those bits. A single interrupt line is high while any pending bit is also unmasked.

The register port is a simple word port: an address, one-cycle write and read strobes, and combinational read data. The controller decodes the per-channel register banks that lie above the global registers. It tells the channel logic which bank is addressed and the offset inside it, and it returns that bank's read word. A word-wide mode register holds the clock divider settings and passes them through to the channels. The channel counters live outside this block. They send a one-cycle period-end pulse to the controller and take their run-enable from it.

Top module: `pwm_gctl`

## Requirements
- R1: After reset all channel enables, interrupt masks, pending bits and the mode word are zero, so `irq_o` is low.
- R2: A write to offset 0x04 turns on channel i for every 1 in data bit i. Zero bits leave their channels unchanged. Offset 0x0C reads the enable bits in bits NCH-1:0, and `chan_en_o` shows them from the cycle after the write.
- R3: A write to offset 0x08 turns off channel i for every 1 in data bit i. Zero bits leave their channels unchanged.
- R4: A write to offset 0x10 unmasks channel i for every 1 in bit i, and a write to offset 0x14 masks it. Zero bits have no effect. Offset 0x18 reads the mask, where 1 means unmasked.
- R5: A high `period_end_i[i]` at a clock edge while channel i is enabled sets pending bit i. Offset 0x1C reads the pending bits in bits NCH-1:0 from the next cycle on. A pending bit stays set until it is acknowledged.
- R6: A period-end pulse from a disabled channel is ignored.
- R7: A read strobe at offset 0x1C returns the pending bits and clears every bit it returned at that clock edge.
- R8: A period-end event at the same edge as a read of 0x1C stays pending and shows in the next read.
- R9: `irq_o` is high exactly when some pending bit is set whose mask bit is 1. It follows the registered state with no further delay.
- R10: A write to offset 0x00 stores the whole data word. Offset 0x00 reads it back, and `mode_o` drives it.
- R11: An access at 0x200 + i*0x20 + k, for channel i below NCH, raises only `bank_sel_o[i]` while a strobe is high, puts k on `bank_off_o`, and reads channel i's word from `bank_rdata_i`. Other addresses, and the write-only offsets 0x04, 0x08, 0x10 and 0x14, read as zero.
- R12: Writes to the read-only offsets 0x0C, 0x18 and 0x1C change no enable, mask, pending bit or mode bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr_i | input | AW | Byte address of the register access |
| reg_wr_i | input | 1 | Write strobe, one cycle per write |
| reg_rd_i | input | 1 | Read strobe; acknowledges pending bits at 0x1C |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Read data for the current address |
| bank_sel_o | output | NCH | One-hot select of the addressed channel bank |
| bank_off_o | output | log2(BANK_STRIDE) | Byte offset inside the channel bank |
| bank_rdata_i | input | NCH*DW | Read words of all channel banks, channel 0 in the low word |
| period_end_i | input | NCH | Period-end pulse from each channel counter |
| chan_en_o | output | NCH | Run enable for each channel counter |
| mode_o | output | DW | Mode word for the clock dividers |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is a period-end pulse that arrives at the same clock edge as the acknowledging read. The design must clear the bits it returned and keep the new one. A bench that reads only when idle never hits this case, so the stimulus drives directed collisions, both on a bit already pending and on a fresh bit. It also lets random reads of 0x1C overlap random period-end pulses over thousands of cycles. Pulses from disabled channels, and writes to the read-only offsets, are mixed into the same random stream. A bench model tracks every state bit and checks them through the read port and the interrupt line.

// File: rtl/pwm_gctl_pkg.sv
package pwm_gctl_pkg;

   // Global register byte offsets
   localparam logic [31:0] OFS_MODE  = 32'h00;
   localparam logic [31:0] OFS_ENA   = 32'h04;
   localparam logic [31:0] OFS_DIS   = 32'h08;
   localparam logic [31:0] OFS_STAT  = 32'h0C;
   localparam logic [31:0] OFS_IEN   = 32'h10;
   localparam logic [31:0] OFS_IDIS  = 32'h14;
   localparam logic [31:0] OFS_IMASK = 32'h18;
   localparam logic [31:0] OFS_ISR   = 32'h1C;

   // Address match flags for the global registers
   typedef struct packed {
      logic mode;
      logic ena;
      logic dis;
      logic stat;
      logic ien;
      logic idis;
      logic imask;
      logic isr;
   } gctl_hit_t;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/pwm_gctl_decode.sv
module pwm_gctl_decode
   import pwm_gctl_pkg::*;
#(
   parameter int unsigned AW          = 12,
   parameter int unsigned NCH         = 4,
   parameter int unsigned BANK_BASE   = 32'h200,
   parameter int unsigned BANK_STRIDE = 32'h20,
   localparam int unsigned OFFW       = $clog2(BANK_STRIDE),
   localparam int unsigned IDXW       = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic [AW-1:0]   addr_i,
   input  logic            acc_i,
   output gctl_hit_t       hit_o,
   output logic            bank_hit_o,
   output logic [IDXW-1:0] bank_idx_o,
   output logic [NCH-1:0]  bank_sel_o,
   output logic [OFFW-1:0] bank_off_o
);

   localparam logic [31:0] BASE_W = 32'(BANK_BASE);
   localparam logic [31:0] SPAN_W = 32'(NCH * BANK_STRIDE);

   logic [31:0] addr_w;
   logic [31:0] rel_w;

   assign addr_w = 32'(addr_i);
   assign rel_w  = addr_w - BASE_W;

   always_comb begin
      hit_o.mode  = (addr_w == OFS_MODE);
      hit_o.ena   = (addr_w == OFS_ENA);
      hit_o.dis   = (addr_w == OFS_DIS);
      hit_o.stat  = (addr_w == OFS_STAT);
      hit_o.ien   = (addr_w == OFS_IEN);
      hit_o.idis  = (addr_w == OFS_IDIS);
      hit_o.imask = (addr_w == OFS_IMASK);
      hit_o.isr   = (addr_w == OFS_ISR);
   end

   // Bank window: BASE .. BASE + NCH*STRIDE - 1
   assign bank_hit_o = (addr_w >= BASE_W) && (rel_w < SPAN_W);
   assign bank_idx_o = rel_w[OFFW +: IDXW];
   assign bank_off_o = rel_w[OFFW-1:0];

   generate
      for (genvar gi = 0; gi < NCH; gi++) begin : g_bank_sel
         assign bank_sel_o[gi] = acc_i && bank_hit_o &&
                                 (rel_w[OFFW +: IDXW] == IDXW'(gi));
      end
   endgenerate

   // A global register and a bank can never share an address
   always_comb begin
      AST_GLOBAL_NOT_IN_BANK: assert (!(bank_hit_o && (hit_o != '0))); // R11
   end

endmodule

// File: rtl/pwm_gctl_w1sc.sv
module pwm_gctl_w1sc #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_i,
   input  logic         clr_i,
   input  logic [W-1:0] bits_i,
   output logic [W-1:0] q_o
);

   logic [W-1:0] q_r;

   always_ff @(posedge clk) begin
      if (!rst_n)
         q_r <= '0;
      else if (set_i)
         q_r <= q_r | bits_i;
      else if (clr_i)
         q_r <= q_r & ~bits_i;
   end

   assign q_o = q_r;

   // Set and clear come from different offsets of a single-access port
   AST_SET_CLR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_i && clr_i)); // R3

   AST_W1S_ONES_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> ((q_o & $past(bits_i)) == $past(bits_i))); // R2

   AST_W1S_ZEROS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> (((q_o ^ $past(q_o)) & ~$past(bits_i)) == '0)); // R2

   AST_W1C_ONES_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> ((q_o & $past(bits_i)) == '0)); // R3

   AST_W1C_ZEROS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> (((q_o ^ $past(q_o)) & ~$past(bits_i)) == '0)); // R3

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !clr_i) |=> $stable(q_o)); // R12

endmodule

// File: rtl/pwm_gctl_irq.sv
module pwm_gctl_irq #(
   parameter int unsigned NCH     = 4,
   parameter int unsigned IRQ_REG = 0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] evt_i,
   input  logic [NCH-1:0] en_i,
   input  logic           ack_i,
   input  logic [NCH-1:0] mask_i,
   output logic [NCH-1:0] stat_o,
   output logic           irq_o
);

   logic [NCH-1:0] stat_q;
   logic [NCH-1:0] evt_live;
   logic [NCH-1:0] ack_bits;

   assign evt_live = evt_i & en_i;
   assign ack_bits = ack_i ? stat_q : '0;

   // Acknowledge removes only what was returned; new events win
   always_ff @(posedge clk) begin
      if (!rst_n)
         stat_q <= '0;
      else
         stat_q <= (stat_q & ~ack_bits) | evt_live;
   end

   assign stat_o = stat_q;

   generate
      if (IRQ_REG == 0) begin : g_irq_comb
         assign irq_o = |(stat_q & mask_i);

         AST_IRQ_NEEDS_UNMASK: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_i == '0) |-> !irq_o); // R9
         AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_q == '0) |-> !irq_o); // R9
      end else begin : g_irq_flop
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               irq_q <= 1'b0;
            else
               irq_q <= |(stat_q & mask_i);
         end
         assign irq_o = irq_q;

         AST_IRQ_NEEDS_UNMASK: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(mask_i) == '0) |-> !irq_o); // R9
         AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(stat_q) == '0) |-> !irq_o); // R9
      end
   endgenerate

   AST_DISABLED_EVT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_q & ~$past(stat_q) & ~$past(en_i)) == '0)); // R6

   AST_EVT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_live != '0) |=> ((stat_q & $past(evt_live)) == $past(evt_live))); // R5

   AST_PENDING_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_i |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R5

   AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      ack_i |=> ((stat_q & $past(stat_q) & ~$past(evt_live)) == '0)); // R7

   AST_COLLIDE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && (evt_live != '0)) |=> (stat_q != '0)); // R8

endmodule

// File: rtl/pwm_gctl.sv
module pwm_gctl
   import pwm_gctl_pkg::*;
#(
   parameter int unsigned AW          = 12,
   parameter int unsigned DW          = 32,
   parameter int unsigned NCH         = 4,
   parameter int unsigned BANK_BASE   = 32'h200,
   parameter int unsigned BANK_STRIDE = 32'h20,
   parameter int unsigned IRQ_REG     = 0,
   localparam int unsigned OFFW       = $clog2(BANK_STRIDE),
   localparam int unsigned IDXW       = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     reg_addr_i,
   input  logic              reg_wr_i,
   input  logic              reg_rd_i,
   input  logic [DW-1:0]     reg_wdata_i,
   output logic [DW-1:0]     reg_rdata_o,
   output logic [NCH-1:0]    bank_sel_o,
   output logic [OFFW-1:0]   bank_off_o,
   input  logic [NCH*DW-1:0] bank_rdata_i,
   input  logic [NCH-1:0]    period_end_i,
   output logic [NCH-1:0]    chan_en_o,
   output logic [DW-1:0]     mode_o,
   output logic              irq_o
);

   // ---------------- elaboration-time parameter checks ----------------
   generate
      if (NCH < 1 || NCH > 32) begin : g_bad_nch
         $error("pwm_gctl: NCH must lie in 1..32");
      end
      if (DW < NCH) begin : g_bad_dw
         $error("pwm_gctl: DW must hold one bit per channel");
      end
      if (AW > 32 || AW < 8) begin : g_bad_aw
         $error("pwm_gctl: AW must lie in 8..32");
      end
      if (!is_pow2(BANK_STRIDE) || BANK_STRIDE < 4) begin : g_bad_stride
         $error("pwm_gctl: BANK_STRIDE must be a power of two of at least 4");
      end
      if ((BANK_BASE % BANK_STRIDE) != 0 || BANK_BASE <= OFS_ISR) begin : g_bad_base
         $error("pwm_gctl: BANK_BASE must be stride aligned and above the global registers");
      end
      if (AW < 32 && (BANK_BASE + NCH * BANK_STRIDE) > (64'd1 << AW)) begin : g_bad_span
         $error("pwm_gctl: channel banks exceed the address space");
      end
      if (IRQ_REG > 1) begin : g_bad_irq
         $error("pwm_gctl: IRQ_REG must be 0 or 1");
      end
   endgenerate

   // ---------------- address decode ----------------
   gctl_hit_t        hit;
   logic             bank_hit;
   logic [IDXW-1:0]  bank_idx;

   pwm_gctl_decode #(
      .AW          (AW),
      .NCH         (NCH),
      .BANK_BASE   (BANK_BASE),
      .BANK_STRIDE (BANK_STRIDE)
   ) u_decode (
      .addr_i     (reg_addr_i),
      .acc_i      (reg_wr_i | reg_rd_i),
      .hit_o      (hit),
      .bank_hit_o (bank_hit),
      .bank_idx_o (bank_idx),
      .bank_sel_o (bank_sel_o),
      .bank_off_o (bank_off_o)
   );

   // ---------------- channel enables ----------------
   logic [NCH-1:0] en_q;

   pwm_gctl_w1sc #(.W(NCH)) u_enable (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (reg_wr_i & hit.ena),
      .clr_i  (reg_wr_i & hit.dis),
      .bits_i (reg_wdata_i[NCH-1:0]),
      .q_o    (en_q)
   );

   // ---------------- interrupt mask ----------------
   logic [NCH-1:0] mask_q;

   pwm_gctl_w1sc #(.W(NCH)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (reg_wr_i & hit.ien),
      .clr_i  (reg_wr_i & hit.idis),
      .bits_i (reg_wdata_i[NCH-1:0]),
      .q_o    (mask_q)
   );

   // ---------------- pending bits and interrupt line ----------------
   logic [NCH-1:0] stat_q;

   pwm_gctl_irq #(
      .NCH     (NCH),
      .IRQ_REG (IRQ_REG)
   ) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (period_end_i),
      .en_i   (en_q),
      .ack_i  (reg_rd_i & hit.isr),
      .mask_i (mask_q),
      .stat_o (stat_q),
      .irq_o  (irq_o)
   );

   // ---------------- mode word ----------------
   logic [DW-1:0] mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         mode_q <= '0;
      else if (reg_wr_i && hit.mode)
         mode_q <= reg_wdata_i;
   end

   // ---------------- read path ----------------
   logic [DW-1:0] bank_word [NCH];

   generate
      for (genvar gi = 0; gi < NCH; gi++) begin : g_bank_word
         assign bank_word[gi] = bank_rdata_i[gi*DW +: DW];
      end
   endgenerate

   always_comb begin
      reg_rdata_o = '0;
      if (bank_hit)
         reg_rdata_o = bank_word[bank_idx];
      else if (hit.mode)
         reg_rdata_o = mode_q;
      else if (hit.stat)
         reg_rdata_o = DW'(en_q);
      else if (hit.imask)
         reg_rdata_o = DW'(mask_q);
      else if (hit.isr)
         reg_rdata_o = DW'(stat_q);
   end

   assign chan_en_o = en_q;
   assign mode_o    = mode_q;

   // ---------------- assertions ----------------
   AST_RO_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && (hit.stat || hit.imask || hit.isr)) |=>
         ($stable(chan_en_o) && $stable(mask_q) && $stable(mode_o))); // R12

   AST_MODE_STORES: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && hit.mode) |=> (mode_o == $past(reg_wdata_i))); // R10

   AST_BANK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_sel_o)); // R11

   AST_BANK_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_wr_i && !reg_rd_i) |-> (bank_sel_o == '0)); // R11

endmodule

// File: tb/pwm_gctl_tb_top.sv
`timescale 1ns/1ps
module pwm_gctl_tb_top;

   localparam int NCH = 4;
   localparam int DW  = 32;
   localparam int AW  = 12;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [AW-1:0]     reg_addr;
   logic              reg_wr;
   logic              reg_rd;
   logic [DW-1:0]     reg_wdata;
   logic [DW-1:0]     reg_rdata;
   logic [NCH-1:0]    bank_sel;
   logic [4:0]        bank_off;
   logic [NCH*DW-1:0] bank_rdata;
   logic [NCH-1:0]    period_end;
   logic [NCH-1:0]    chan_en;
   logic [DW-1:0]     mode;
   logic              irq;

   int n_chk = 0;
   int n_err = 0;

   // model state
   logic [NCH-1:0] m_en   = '0;
   logic [NCH-1:0] m_mask = '0;
   logic [NCH-1:0] m_stat = '0;
   logic [DW-1:0]  m_mode = '0;

   always #4 clk = ~clk;  // 125 MHz

   pwm_gctl dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .reg_addr_i   (reg_addr),
      .reg_wr_i     (reg_wr),
      .reg_rd_i     (reg_rd),
      .reg_wdata_i  (reg_wdata),
      .reg_rdata_o  (reg_rdata),
      .bank_sel_o   (bank_sel),
      .bank_off_o   (bank_off),
      .bank_rdata_i (bank_rdata),
      .period_end_i (period_end),
      .chan_en_o    (chan_en),
      .mode_o       (mode),
      .irq_o        (irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   function automatic bit in_bank(input logic [AW-1:0] a);
      return (a >= 12'h200) && (a < 12'h280);
   endfunction

   function automatic logic [31:0] exp_rdata(input logic [AW-1:0] a);
      if (in_bank(a)) return bank_rdata[((a - 12'h200) >> 5) * DW +: DW];
      case (a)
         12'h000: return m_mode;
         12'h00C: return 32'(m_en);
         12'h018: return 32'(m_mask);
         12'h01C: return 32'(m_stat);
         default: return 32'h0;
      endcase
   endfunction

   function automatic string tag_for(input logic [AW-1:0] a);
      case (a)
         12'h000: return "R10";
         12'h00C: return "R2";
         12'h018: return "R4";
         12'h01C: return "R7";
         default: return "R11";
      endcase
   endfunction

   task automatic step(input logic wr, input logic rd, input logic [AW-1:0] a,
                       input logic [DW-1:0] wd, input logic [NCH-1:0] pe);
      logic [NCH-1:0] ack;
      logic [NCH-1:0] evt;
      logic [NCH-1:0] exp_sel;
      @(negedge clk);
      reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd; period_end = pe;
      #1;
      chk(tag_for(a), reg_rdata, exp_rdata(a));
      chk("R2", 32'(chan_en), 32'(m_en));
      chk("R9", 32'(irq), 32'(|(m_stat & m_mask)));
      chk("R10", mode, m_mode);
      exp_sel = '0;
      if (in_bank(a) && (wr || rd)) exp_sel[(a - 12'h200) >> 5] = 1'b1;
      chk("R11", 32'(bank_sel), 32'(exp_sel));
      if (in_bank(a)) chk("R11", 32'(bank_off), 32'((a - 12'h200) & 12'h1F));
      @(posedge clk);
      ack = (rd && a == 12'h01C) ? m_stat : '0;
      evt = pe & m_en;                        // R6: disabled channels ignored
      m_stat = (m_stat & ~ack) | evt;         // R7, R8
      if (wr) begin
         case (a)
            12'h000: m_mode = wd;
            12'h004: m_en   = m_en | wd[NCH-1:0];
            12'h008: m_en   = m_en & ~wd[NCH-1:0];
            12'h010: m_mask = m_mask | wd[NCH-1:0];
            12'h014: m_mask = m_mask & ~wd[NCH-1:0];
            default: ;
         endcase
      end
   endtask

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [AW-1:0] ra;
      void'($urandom(32'd7351));
      rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
      period_end = '0;
      bank_rdata = {32'hC0DE_0003, 32'hC0DE_0002, 32'hC0DE_0001, 32'hC0DE_0000};
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", 32'(chan_en), 32'h0);
      chk("R1", 32'(irq), 32'h0);
      chk("R1", mode, 32'h0);
      rst_n = 1'b1;
      // R1: all readable registers zero
      step(0, 1, 12'h00C, 0, 0);
      step(0, 1, 12'h018, 0, 0);
      step(0, 1, 12'h01C, 0, 0);
      step(0, 1, 12'h000, 0, 0);
      // R2: set with zero bits leaving others alone
      step(1, 0, 12'h004, 32'h5, 0);
      step(1, 0, 12'h004, 32'h2, 0);
      step(0, 1, 12'h00C, 0, 0);
      // R3: clear one bit
      step(1, 0, 12'h008, 32'h4, 0);
      step(0, 1, 12'h00C, 0, 0);
      // R4: unmask then mask
      step(1, 0, 12'h010, 32'h9, 0);
      step(1, 0, 12'h014, 32'h8, 0);
      step(0, 1, 12'h018, 0, 0);
      // R5, R9: enabled unmasked channel 0 raises pending and irq
      step(0, 0, 12'h000, 0, 4'h1);
      step(0, 0, 12'h01C, 0, 0);
      // R6: channel 3 disabled, its pulse ignored
      step(0, 0, 12'h000, 0, 4'h8);
      step(0, 0, 12'h01C, 0, 0);
      // R8: read collides with a fresh event on channel 1 and a repeat on channel 0
      step(0, 1, 12'h01C, 0, 4'h3);
      step(0, 1, 12'h01C, 0, 0);
      step(0, 1, 12'h01C, 0, 0);
      // R12: writes to read-only offsets
      step(0, 0, 12'h000, 0, 4'h2);
      step(1, 0, 12'h00C, 32'hFFFF_FFFF, 0);
      step(1, 0, 12'h018, 32'hFFFF_FFFF, 0);
      step(1, 0, 12'h01C, 32'hFFFF_FFFF, 0);
      step(0, 0, 12'h01C, 0, 0);
      // R10: mode word
      step(1, 0, 12'h000, 32'hA5C3_1E0F, 0);
      step(0, 1, 12'h000, 0, 0);
      // R11: bank edges and write-only offsets
      step(0, 1, 12'h1FC, 0, 0);
      step(0, 1, 12'h200, 0, 0);
      step(1, 0, 12'h224, 32'h1, 0);
      step(0, 1, 12'h27C, 0, 0);
      step(0, 1, 12'h280, 0, 0);
      step(0, 1, 12'h004, 0, 0);
      step(0, 1, 12'h014, 0, 0);

      // random mix
      for (int n = 0; n < 3000; n++) begin
         int op;
         logic [NCH-1:0] pe;
         op = $urandom % 12;
         pe = (($urandom % 3) == 0) ? NCH'($urandom) : '0;
         if (($urandom % 8) == 0)
            bank_rdata = {$urandom, $urandom, $urandom, $urandom};
         case (op)
            0, 1:  step(1, 0, 12'h004, $urandom, pe);
            2:     step(1, 0, 12'h008, $urandom, pe);
            3:     step(1, 0, 12'h010, $urandom, pe);
            4:     step(1, 0, 12'h014, $urandom, pe);
            5, 6:  step(0, 1, 12'h01C, 0, pe);
            7:     step(1, 0, 12'h000, $urandom, pe);
            8:     begin
                      case ($urandom % 3)
                         0: ra = 12'h00C;
                         1: ra = 12'h018;
                         default: ra = 12'h01C;
                      endcase
                      step(1, 0, ra, $urandom, pe);
                   end
            9:     step(0, 1, 12'h200 + AW'(($urandom % 32) * 4), 0, pe);
            10:    step(0, 1, AW'($urandom) & 12'hFFC, 0, pe);
            default: step(0, 0, 12'h00C, 0, pe);
         endcase
      end

      @(negedge clk);
      reg_wr = 0; reg_rd = 0; period_end = '0;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule